// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Not-Recently-Used Replacement

The block caches virtual-to-physical page translations in a small set of fully associative entries. Each entry carries a virtual page number, a 3-bit page-size code (page size is 8 KB times 8 to the power of the code), a partition number, a context number, a real-mode flag, a lock bit, a valid bit, a used bit and a physical page number. Commands arrive one per clock on a valid/ready interface whose ready is always high. Each accepted command produces exactly one registered response on the next clock.

The commands cover several jobs. A lookup returns the matching entry and forms the physical address. An insert either overwrites a named slot or picks a victim itself. Three demap commands remove one page, a whole context or the unlocked part of a partition, and a flush clears every entry. Two diagnostic reads return a packed tag word or a packed data word for a given slot. Replacement follows a used-bit not-recently-used scheme. A hit or an insert sets the entry's used bit. When that leaves every entry used, the used bits of all unlocked entries are cleared, except for the entry just touched.

Top module: `nru_tlb`

## Requirements
- R1: Every command taken while cmd_valid is high raises rsp_valid for exactly the next clock cycle. cmd_ready is always high. Op codes on cmd_op: 0 lookup, 1 insert, 2 demap page, 3 demap context, 4 demap partition, 5 flush, 6 read tag, 7 read data.
- R2: A lookup (op 0) hits only on a valid entry whose partition, context and real flag equal the request's and whose virtual page bits above the entry's page size equal the request's. On a hit, rsp_hit is 1 and rsp_idx is the slot. Otherwise rsp_hit is 0.
- R3: On a hit, rsp_pa is the entry's physical page (page number shifted left by 13) with its low 13+3*code bits cleared, ORed with those same low bits of the virtual address.
- R4: An insert (op 1) with cmd_idx_en=0 writes the lowest slot that is invalid or has its used bit clear. If there is no such slot, it writes the last slot. With cmd_idx_en=1 it writes slot cmd_idx, and an index beyond the last slot selects the last slot. rsp_idx reports the slot written.
- R5: An insert first invalidates, and clears the used bit of, every other valid entry that has the same partition, context and real flag and whose virtual page agrees above the larger of the two page sizes.
- R6: A new entry is valid and used. When a hit or an insert sets a used bit and every entry is then used, all unlocked entries lose their used bit except the one just touched.
- R7: Demap page (op 2) invalidates, and clears the used bit of, every entry that a lookup with the same fields would hit.
- R8: Demap context (op 3) invalidates every entry whose partition and context both match, whatever its lock bit.
- R9: Demap partition (op 4) invalidates every unlocked entry of the given partition. Locked entries and other partitions stay.
- R10: Flush (op 5) clears every valid and used bit, including those of locked entries.
- R11: Read tag (op 6) returns the tag word for slot cmd_idx on rsp_data. The context is in bits 12:0 and the virtual address page bits are at their own positions up to bit VA_W-1. The partition occupies bits 63:61, the real flag bit 60, and the inverted size code bits 58:56.
- R12: Read data (op 7) returns the data word for slot cmd_idx on rsp_data. Bit 63 holds valid, bit 62 used and bit 61 lock. The size code is in bits 58:56 and the physical page is at bits PA_W-1:13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always 1 |
| cmd_op | input | 3 | Command code |
| cmd_va | input | VA_W | Virtual address (or page for insert) |
| cmd_part | input | PART_W | Partition number |
| cmd_ctx | input | CTX_W | Context number |
| cmd_real | input | 1 | Real-mode flag |
| cmd_size | input | 3 | Page-size code for insert |
| cmd_lock | input | 1 | Lock bit for insert |
| cmd_ppn | input | PA_W-13 | Physical page number for insert |
| cmd_idx_en | input | 1 | Insert uses cmd_idx |
| cmd_idx | input | IDX_W | Slot index for explicit insert and reads |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_idx | output | IDX_W | Hit slot or slot written |
| rsp_pa | output | PA_W | Formed physical address |
| rsp_data | output | 64 | Diagnostic readback word |

## Verification
The block registers every result once, so each response, and each state change a command causes, is visible one clock after the command edge. The bench raises a command on a falling edge and drops it on the next falling edge. It then samples the response at that second falling edge, half a cycle after the registering edge. It observes state changes such as demaps and used-bit clearing only through later lookups and readbacks, each issued as its own command and sampled the same way. No check relies on values from inside the design.

// File: rtl/nru_tlb_pkg.sv
package nru_tlb_pkg;
    localparam int BASE_SHIFT = 13;
    localparam int SIZE_W     = 3;

    typedef enum logic [2:0] {
        OP_LOOKUP     = 3'd0,
        OP_INSERT     = 3'd1,
        OP_DEMAP_PAGE = 3'd2,
        OP_DEMAP_CTX  = 3'd3,
        OP_DEMAP_PART = 3'd4,
        OP_FLUSH      = 3'd5,
        OP_READ_TAG   = 3'd6,
        OP_READ_DATA  = 3'd7
    } tlb_op_e;
endpackage

// File: rtl/nru_tlb_match.sv
module nru_tlb_match
    import nru_tlb_pkg::*;
#(
    parameter int VPN_W  = 35,
    parameter int PART_W = 3,
    parameter int CTX_W  = 13
) (
    input  logic              e_valid,
    input  logic [VPN_W-1:0]  e_vpn,
    input  logic [SIZE_W-1:0] e_size,
    input  logic [PART_W-1:0] e_part,
    input  logic [CTX_W-1:0]  e_ctx,
    input  logic              e_rmode,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [SIZE_W-1:0] q_size,
    input  logic [PART_W-1:0] q_part,
    input  logic [CTX_W-1:0]  q_ctx,
    input  logic              q_rmode,
    output logic              page_hit,
    output logic              key_clash,
    output logic              ctx_hit,
    output logic              part_hit
);
    logic [VPN_W-1:0]  diff;
    logic [VPN_W-1:0]  ign_e;
    logic [VPN_W-1:0]  ign_m;
    logic [SIZE_W-1:0] big;
    logic              same_part;
    logic              same_id;

    always_comb begin
        diff      = e_vpn ^ q_vpn;
        big       = (e_size > q_size) ? e_size : q_size;
        ign_e     = ~({VPN_W{1'b1}} << (3 * int'(e_size)));
        ign_m     = ~({VPN_W{1'b1}} << (3 * int'(big)));
        same_part = (e_part == q_part);
        same_id   = same_part && (e_ctx == q_ctx) && (e_rmode == q_rmode);
        page_hit  = e_valid && same_id && ((diff & ~ign_e) == '0);
        key_clash = e_valid && same_id && ((diff & ~ign_m) == '0);
        ctx_hit   = e_valid && same_part && (e_ctx == q_ctx);
        part_hit  = e_valid && same_part;
    end
endmodule

// File: rtl/nru_tlb_first.sv
module nru_tlb_first #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/nru_tlb.sv
module nru_tlb
    import nru_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 48,
    parameter int PA_W    = 40,
    parameter int PART_W  = 3,
    parameter int CTX_W   = 13,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int VPN_W  = VA_W - BASE_SHIFT,
    localparam int PPN_W  = PA_W - BASE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [VA_W-1:0]   cmd_va,
    input  logic [PART_W-1:0] cmd_part,
    input  logic [CTX_W-1:0]  cmd_ctx,
    input  logic              cmd_real,
    input  logic [2:0]        cmd_size,
    input  logic              cmd_lock,
    input  logic [PPN_W-1:0]  cmd_ppn,
    input  logic              cmd_idx_en,
    input  logic [IDX_W-1:0]  cmd_idx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [63:0]       rsp_data
);
    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0]             used;
        logic [ENTRIES-1:0]             lock;
        logic [ENTRIES-1:0]             rmode;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][SIZE_W-1:0] size;
        logic [ENTRIES-1:0][PART_W-1:0] part;
        logic [ENTRIES-1:0][CTX_W-1:0]  ctx;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        logic                           rsp_valid;
        logic                           rsp_hit;
        logic [IDX_W-1:0]               rsp_idx;
        logic [PA_W-1:0]                rsp_pa;
        logic [63:0]                    rsp_data;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] page_hit;
    logic [ENTRIES-1:0] key_clash;
    logic [ENTRIES-1:0] ctx_hit;
    logic [ENTRIES-1:0] part_hit;
    logic [ENTRIES-1:0] free_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx;
    logic [VPN_W-1:0]   q_vpn;
    tlb_op_e            op;

    assign q_vpn     = cmd_va[VA_W-1:BASE_SHIFT];
    assign op        = tlb_op_e'(cmd_op);
    assign cmd_ready = 1'b1;
    assign free_vec  = ~s_q.valid | ~s_q.used;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        nru_tlb_match #(
            .VPN_W (VPN_W),
            .PART_W(PART_W),
            .CTX_W (CTX_W)
        ) u_m (
            .e_valid  (s_q.valid[g]),
            .e_vpn    (s_q.vpn[g]),
            .e_size   (s_q.size[g]),
            .e_part   (s_q.part[g]),
            .e_ctx    (s_q.ctx[g]),
            .e_rmode  (s_q.rmode[g]),
            .q_vpn    (q_vpn),
            .q_size   (cmd_size),
            .q_part   (cmd_part),
            .q_ctx    (cmd_ctx),
            .q_rmode  (cmd_real),
            .page_hit (page_hit[g]),
            .key_clash(key_clash[g]),
            .ctx_hit  (ctx_hit[g]),
            .part_hit (part_hit[g])
        );
    end

    nru_tlb_first #(.N(ENTRIES), .IW(IDX_W)) u_hit (
        .req  (page_hit),
        .found(hit_any),
        .idx  (hit_idx)
    );

    nru_tlb_first #(.N(ENTRIES), .IW(IDX_W)) u_free (
        .req  (free_vec),
        .found(free_any),
        .idx  (free_idx)
    );

    // Mark one entry used; on saturation keep only locked ones and the touched one.
    function automatic logic [ENTRIES-1:0] touch(input logic [ENTRIES-1:0] used,
                                                 input logic [ENTRIES-1:0] lock,
                                                 input logic [IDX_W-1:0]   at);
        logic [ENTRIES-1:0] one;
        logic [ENTRIES-1:0] u;
        one = ENTRIES'(1) << at;
        u   = used | one;
        if (&u) begin
            u = (u & lock) | one;
        end
        return u;
    endfunction

    logic [IDX_W-1:0]  slot;
    logic [IDX_W-1:0]  rd_idx;
    logic [PA_W-1:0]   off_mask;
    logic [PA_W-1:0]   page_full;
    logic [63:0]       tag_word;
    logic [63:0]       data_word;
    logic [ENTRIES-1:0] kill;

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = cmd_valid;
        s_d.rsp_hit   = 1'b0;
        s_d.rsp_idx   = '0;
        s_d.rsp_pa    = '0;
        s_d.rsp_data  = '0;

        if (cmd_idx_en) begin
            slot = (int'(cmd_idx) >= ENTRIES) ? IDX_W'(ENTRIES - 1) : cmd_idx;
        end else if (free_any) begin
            slot = free_idx;
        end else begin
            slot = IDX_W'(ENTRIES - 1);
        end
        rd_idx = (int'(cmd_idx) >= ENTRIES) ? IDX_W'(ENTRIES - 1) : cmd_idx;

        off_mask  = ~({PA_W{1'b1}} << (BASE_SHIFT + 3 * int'(s_q.size[hit_idx])));
        page_full = {s_q.ppn[hit_idx], {BASE_SHIFT{1'b0}}};

        tag_word = '0;
        tag_word[CTX_W-1:0]          = s_q.ctx[rd_idx];
        tag_word[VA_W-1:BASE_SHIFT]  = s_q.vpn[rd_idx];
        tag_word[63 -: PART_W]       = s_q.part[rd_idx];
        tag_word[60]                 = s_q.rmode[rd_idx];
        tag_word[58:56]              = ~s_q.size[rd_idx];

        data_word = '0;
        data_word[63]               = s_q.valid[rd_idx];
        data_word[62]               = s_q.used[rd_idx];
        data_word[61]               = s_q.lock[rd_idx];
        data_word[58:56]            = s_q.size[rd_idx];
        data_word[PA_W-1:BASE_SHIFT] = s_q.ppn[rd_idx];

        kill = '0;

        if (cmd_valid) begin
            case (op)
                OP_LOOKUP: begin
                    if (hit_any) begin
                        s_d.rsp_hit = 1'b1;
                        s_d.rsp_idx = hit_idx;
                        s_d.rsp_pa  = (page_full & ~off_mask) | (cmd_va[PA_W-1:0] & off_mask);
                        s_d.used    = touch(s_q.used, s_q.lock, hit_idx);
                    end
                end
                OP_INSERT: begin
                    kill             = key_clash;
                    s_d.valid        = s_q.valid & ~kill;
                    s_d.used         = s_q.used & ~kill;
                    s_d.vpn[slot]    = q_vpn;
                    s_d.size[slot]   = cmd_size;
                    s_d.part[slot]   = cmd_part;
                    s_d.ctx[slot]    = cmd_ctx;
                    s_d.rmode[slot]  = cmd_real;
                    s_d.ppn[slot]    = cmd_ppn;
                    s_d.lock[slot]   = cmd_lock;
                    s_d.valid[slot]  = 1'b1;
                    s_d.used         = touch(s_d.used, s_d.lock, slot);
                    s_d.rsp_idx      = slot;
                end
                OP_DEMAP_PAGE: begin
                    kill = page_hit;
                end
                OP_DEMAP_CTX: begin
                    kill = ctx_hit;
                end
                OP_DEMAP_PART: begin
                    kill = part_hit & ~s_q.lock;
                end
                OP_FLUSH: begin
                    kill = '1;
                end
                OP_READ_TAG: begin
                    s_d.rsp_idx  = rd_idx;
                    s_d.rsp_data = tag_word;
                end
                OP_READ_DATA: begin
                    s_d.rsp_idx  = rd_idx;
                    s_d.rsp_data = data_word;
                end
                default: begin
                end
            endcase
            if (op != OP_INSERT) begin
                s_d.valid = s_d.valid & ~kill;
                s_d.used  = s_d.used & ~kill;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_hit   = s_q.rsp_hit;
    assign rsp_idx   = s_q.rsp_idx;
    assign rsp_pa    = s_q.rsp_pa;
    assign rsp_data  = s_q.rsp_data;

    logic [ENTRIES-1:0] used_vec;
    logic [ENTRIES-1:0] lock_vec;
    assign used_vec = s_q.used;
    assign lock_vec = s_q.lock;
endmodule

// File: rtl/nru_tlb_chk.sv
module nru_tlb_chk #(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 48,
    parameter int PA_W    = 40,
    parameter int IDX_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [2:0]         cmd_op,
    input logic [VA_W-1:0]    cmd_va,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [IDX_W-1:0]   rsp_idx,
    input logic [PA_W-1:0]    rsp_pa,
    input logic [ENTRIES-1:0] page_hit,
    input logic [ENTRIES-1:0] used_vec,
    input logic [ENTRIES-1:0] lock_vec
);
    // R1
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
    // R1
    a_r1_rsp_caused: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid));
    // R5
    a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(page_hit));
    // R6
    a_r6_hit_is_used: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> used_vec[rsp_idx]);
    // R6
    a_r6_saturation_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (&used_vec) |-> ($countones(used_vec & ~lock_vec) <= 1));
    // R3
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_pa[12:0] == $past(cmd_va[12:0])));
    // R2
    a_r2_hit_only_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ($past(cmd_op) == 3'd0));
endmodule

bind nru_tlb nru_tlb_chk #(
    .ENTRIES(ENTRIES),
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_va   (cmd_va),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_idx  (rsp_idx),
    .rsp_pa   (rsp_pa),
    .page_hit (page_hit),
    .used_vec (used_vec),
    .lock_vec (lock_vec)
);

// File: tb/sim_nru_tlb.sv
`timescale 1ns/1ps
module sim_nru_tlb;
    localparam int ENTRIES = 8;
    localparam int VA_W    = 48;
    localparam int PA_W    = 40;
    localparam int PART_W  = 3;
    localparam int CTX_W   = 13;
    localparam int IDX_W   = 3;
    localparam int PPN_W   = PA_W - 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [2:0]        cmd_op = '0;
    logic [VA_W-1:0]   cmd_va = '0;
    logic [PART_W-1:0] cmd_part = '0;
    logic [CTX_W-1:0]  cmd_ctx = '0;
    logic              cmd_real = 1'b0;
    logic [2:0]        cmd_size = '0;
    logic              cmd_lock = 1'b0;
    logic [PPN_W-1:0]  cmd_ppn = '0;
    logic              cmd_idx_en = 1'b0;
    logic [IDX_W-1:0]  cmd_idx = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [IDX_W-1:0]  rsp_idx;
    logic [PA_W-1:0]   rsp_pa;
    logic [63:0]       rsp_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    nru_tlb #(
        .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PART_W(PART_W), .CTX_W(CTX_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_va(cmd_va), .cmd_part(cmd_part), .cmd_ctx(cmd_ctx),
        .cmd_real(cmd_real), .cmd_size(cmd_size), .cmd_lock(cmd_lock),
        .cmd_ppn(cmd_ppn), .cmd_idx_en(cmd_idx_en), .cmd_idx(cmd_idx),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
        .rsp_pa(rsp_pa), .rsp_data(rsp_data)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [VA_W-1:0] va,
                         input logic [PART_W-1:0] part, input logic [CTX_W-1:0] ctx,
                         input logic rl, input logic [2:0] sz, input logic lk,
                         input logic [PPN_W-1:0] ppn, input logic ie,
                         input logic [IDX_W-1:0] ix);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_va = va; cmd_part = part; cmd_ctx = ctx;
        cmd_real = rl; cmd_size = sz; cmd_lock = lk; cmd_ppn = ppn;
        cmd_idx_en = ie; cmd_idx = ix;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [VA_W-1:0] pg(input int p);
        return VA_W'(p) << 13;
    endfunction

    task automatic ins(input logic [VA_W-1:0] va, input logic [PART_W-1:0] part,
                       input logic [CTX_W-1:0] ctx, input logic lk, input logic [2:0] sz,
                       input logic [PPN_W-1:0] ppn);
        issue(3'd1, va, part, ctx, 1'b0, sz, lk, ppn, 1'b0, '0);
    endtask

    task automatic look(input logic [VA_W-1:0] va, input logic [PART_W-1:0] part,
                        input logic [CTX_W-1:0] ctx, input logic rl);
        issue(3'd0, va, part, ctx, rl, 3'd0, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic flush();
        issue(3'd5, '0, '0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid low after reset", 64'(rsp_valid), 64'd0);
        look(pg(5), 3'd0, 13'd1, 1'b0);
        chk("R1 rsp_valid after command", 64'(rsp_valid), 64'd1);
        chk("R2 miss on empty buffer", 64'(rsp_hit), 64'd0);
        @(negedge clk);
        chk("R1 rsp_valid single cycle", 64'(rsp_valid), 64'd0);
        chk("R1 ready high", 64'(cmd_ready), 64'd1);
    endtask

    task automatic t_basic();
        ins(48'h0000_0004_6000, 3'd2, 13'h0011, 1'b0, 3'd0, 27'h155);
        chk("R4 first auto insert slot", 64'(rsp_idx), 64'd0);
        look(48'h0000_0004_7FFC, 3'd2, 13'h0011, 1'b0);
        chk("R2 hit", 64'(rsp_hit), 64'd1);
        chk("R2 hit index", 64'(rsp_idx), 64'd0);
        chk("R3 pa base page", 64'(rsp_pa), 64'h2A_BFFC);
        look(48'h0000_0004_7FFC, 3'd2, 13'h0012, 1'b0);
        chk("R2 other context misses", 64'(rsp_hit), 64'd0);
        look(48'h0000_0004_7FFC, 3'd2, 13'h0011, 1'b1);
        chk("R2 real flag mismatch misses", 64'(rsp_hit), 64'd0);
        look(48'h0000_0004_8000, 3'd2, 13'h0011, 1'b0);
        chk("R2 next page misses", 64'(rsp_hit), 64'd0);
    endtask

    task automatic t_size_and_read();
        issue(3'd1, 48'h0000_0012_0000, 3'd5, 13'h0155, 1'b0, 3'd1, 1'b0, 27'hABF, 1'b1, 3'd5);
        chk("R4 explicit slot", 64'(rsp_idx), 64'd5);
        look(48'h0000_0012_3456, 3'd5, 13'h0155, 1'b0);
        chk("R2 large page hit index", 64'(rsp_idx), 64'd5);
        chk("R3 pa large page masks low page bits", 64'(rsp_pa), 64'h157_3456);
        issue(3'd6, '0, '0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 3'd5);
        chk("R11 tag word", rsp_data, 64'hA600_0000_0012_0155);
        issue(3'd7, '0, '0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 3'd5);
        chk("R12 data word", rsp_data, 64'hC100_0000_0157_E000);
    endtask

    task automatic t_clash();
        ins(48'h0000_0004_6010, 3'd2, 13'h0011, 1'b0, 3'd0, 27'h777);
        chk("R4 lowest free slot", 64'(rsp_idx), 64'd1);
        look(48'h0000_0004_6000, 3'd2, 13'h0011, 1'b0);
        chk("R5 new copy hit", 64'(rsp_idx), 64'd1);
        chk("R5 new pa", 64'(rsp_pa), 64'hEE_E000);
        issue(3'd7, '0, '0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 3'd0);
        chk("R5 old copy invalid", 64'(rsp_data[63]), 64'd0);
        chk("R5 old copy unused", 64'(rsp_data[62]), 64'd0);
        flush();
        look(48'h0000_0012_3456, 3'd5, 13'h0155, 1'b0);
        chk("R10 flush removes entry", 64'(rsp_hit), 64'd0);
        issue(3'd7, '0, '0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 3'd5);
        chk("R10 flushed valid bit", 64'(rsp_data[63]), 64'd0);
    endtask

    task automatic t_nru();
        flush();
        for (int i = 0; i < ENTRIES; i++) begin
            ins(pg(32'h100 + i), 3'd0, 13'd1, 1'b0, 3'd0, 27'(i));
            chk($sformatf("R4 fill slot %0d", i), 64'(rsp_idx), 64'(i));
        end
        issue(3'd7, '0, '0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 3'd3);
        chk("R6 saturation clears used", 64'(rsp_data[62]), 64'd0);
        issue(3'd7, '0, '0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 3'd7);
        chk("R6 last insert keeps used", 64'(rsp_data[62]), 64'd1);
        chk("R6 new entry valid", 64'(rsp_data[63]), 64'd1);
        ins(pg(32'h200), 3'd0, 13'd1, 1'b0, 3'd0, 27'h9);
        chk("R4 victim is unused slot 0", 64'(rsp_idx), 64'd0);
        look(pg(32'h101), 3'd0, 13'd1, 1'b0);
        chk("R2 hit slot 1", 64'(rsp_idx), 64'd1);
        ins(pg(32'h201), 3'd0, 13'd1, 1'b0, 3'd0, 27'hA);
        chk("R6 hit protects slot 1", 64'(rsp_idx), 64'd2);
    endtask

    task automatic t_locked();
        flush();
        for (int i = 0; i < ENTRIES; i++) begin
            ins(pg(32'h100 + i), 3'd0, 13'd1, (i == 0), 3'd0, 27'(i));
        end
        ins(pg(32'h300), 3'd0, 13'd1, 1'b0, 3'd0, 27'h1);
        chk("R6 locked slot 0 keeps used", 64'(rsp_idx), 64'd1);
        flush();
        for (int i = 0; i < ENTRIES; i++) begin
            ins(pg(32'h100 + i), 3'd0, 13'd1, 1'b1, 3'd0, 27'(i));
        end
        ins(pg(32'h300), 3'd0, 13'd1, 1'b1, 3'd0, 27'h1);
        chk("R4 all used goes to last slot", 64'(rsp_idx), 64'(ENTRIES - 1));
        issue(3'd4, '0, 3'd0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, '0);
        look(pg(32'h103), 3'd0, 13'd1, 1'b0);
        chk("R9 locked survives partition demap", 64'(rsp_hit), 64'd1);
        flush();
        look(pg(32'h103), 3'd0, 13'd1, 1'b0);
        chk("R10 flush removes locked", 64'(rsp_hit), 64'd0);
    endtask

    task automatic t_demap_part();
        flush();
        ins(pg(32'h300), 3'd0, 13'd1, 1'b0, 3'd0, 27'h1);
        ins(pg(32'h301), 3'd0, 13'd1, 1'b1, 3'd0, 27'h2);
        ins(pg(32'h302), 3'd1, 13'd1, 1'b0, 3'd0, 27'h3);
        issue(3'd4, '0, 3'd0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, '0);
        look(pg(32'h300), 3'd0, 13'd1, 1'b0);
        chk("R9 unlocked removed", 64'(rsp_hit), 64'd0);
        look(pg(32'h301), 3'd0, 13'd1, 1'b0);
        chk("R9 locked kept", 64'(rsp_hit), 64'd1);
        look(pg(32'h302), 3'd1, 13'd1, 1'b0);
        chk("R9 other partition kept", 64'(rsp_hit), 64'd1);
    endtask

    task automatic t_demap_ctx_page();
        flush();
        ins(pg(32'h400), 3'd0, 13'd2, 1'b0, 3'd0, 27'h1);
        ins(pg(32'h401), 3'd0, 13'd2, 1'b1, 3'd0, 27'h2);
        ins(pg(32'h402), 3'd0, 13'd3, 1'b0, 3'd0, 27'h3);
        ins(pg(32'h403), 3'd1, 13'd2, 1'b0, 3'd0, 27'h4);
        issue(3'd3, '0, 3'd0, 13'd2, 1'b0, 3'd0, 1'b0, '0, 1'b0, '0);
        look(pg(32'h400), 3'd0, 13'd2, 1'b0);
        chk("R8 context entry removed", 64'(rsp_hit), 64'd0);
        look(pg(32'h401), 3'd0, 13'd2, 1'b0);
        chk("R8 locked context entry removed", 64'(rsp_hit), 64'd0);
        look(pg(32'h402), 3'd0, 13'd3, 1'b0);
        chk("R8 other context kept", 64'(rsp_hit), 64'd1);
        look(pg(32'h403), 3'd1, 13'd2, 1'b0);
        chk("R8 other partition kept", 64'(rsp_hit), 64'd1);
        issue(3'd2, pg(32'h402) | 48'h123, 3'd0, 13'd3, 1'b0, 3'd0, 1'b0, '0, 1'b0, '0);
        look(pg(32'h402), 3'd0, 13'd3, 1'b0);
        chk("R7 page removed", 64'(rsp_hit), 64'd0);
        look(pg(32'h403), 3'd1, 13'd2, 1'b0);
        chk("R7 other page kept", 64'(rsp_hit), 64'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_size_and_read();
        t_clash();
        t_nru();
        t_locked();
        t_demap_part();
        t_demap_ctx_page();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule